// File: doc/BRIEF.md
# Parallel-Bus SAR ADC Host Controller

This block sits on the host side of a parallel-bus successive-approximation ADC and runs one conversion for each request it receives. A request carries the input channel, range, polarity, clock-mode field, acquisition style and, for the hold-open style, an acquisition length in system-clock cycles. The request is accepted on a valid/ready handshake. The controller then builds the 8-bit control byte and drives chip-select, write strobe and data lines with parameterised setup, strobe and hold counts. It waits for the ADC's active-low completion interrupt, reads the 12-bit result with a read strobe, and returns the result widened to 16 bits together with its channel tag.

With internal acquisition, one write starts the acquisition and the conversion together. With hold-open acquisition, the controller issues two writes. The first keeps the sampler open. After the programmed number of cycles, the second write closes it and starts the conversion, carrying identical channel, range and polarity bits. No other write is issued while a conversion is outstanding. Leaving the conversion is possible only through an explicit abort or the interrupt timeout, which flags an error and returns to idle.

Top module: `adcb_host_ctrl`

## Requirements
- R1: The control byte on `bus_wdata` is laid out as bits [2:0] channel, bit 3 range, bit 4 bipolar, bit 5 acquisition-style bit (1 keeps the sampler open), bits [7:6] clock-mode field. `bus_oe` is high only while chip-select is low in a write transaction, and the byte is stable across the rising edge of the write strobe.
- R2: Each bus transaction holds chip-select low for SETUP_CYC + STROBE_CYC + HOLD_CYC cycles. The write or read strobe is low for exactly STROBE_CYC of those cycles.
- R3: An internal-acquisition request produces exactly one write, with bit 5 at 0.
- R4: A hold-open request produces two writes. The first has bit 5 at 1 and the second has bit 5 at 0, and bits [4:0] and [7:6] are identical on both. Chip-select stays high between them for max(acq_cycles, 1) cycles.
- R5: Between the write that starts a conversion and the read of its result, no further write is issued.
- R6: The read strobe falls only after the interrupt has gone low. The data bus is not driven while a read is in progress. An interrupt level seen in the first SYNC_STAGES cycles after the converting write is ignored.
- R7: `rsp_valid` pulses for one cycle per completed conversion, with `rsp_chan` equal to the request channel. `rsp_data` holds the 12-bit result zero-extended when unipolar (bit 4 = 0) and sign-extended when bipolar (bit 4 = 1).
- R8: If the interrupt is not seen within TIMEOUT_CYC cycles after the converting write, `err_timeout` pulses for one cycle, no response is produced, and the controller is idle again.
- R9: `abort`, asserted while waiting for the interrupt or during the hold-open interval, returns the controller to idle with no response.
- R10: After reset, chip-select and both strobes are high, `bus_oe` is low, `req_ready` is high, and `rsp_valid` and `err_timeout` are low.
- R11: `req_ready` is high only in idle, and drops in the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_chan | input | 3 | Input channel |
| req_range | input | 1 | Range select bit |
| req_bipolar | input | 1 | 1 = bipolar (two's complement result) |
| req_clk_mode | input | 2 | Clock-mode field for bits [7:6] |
| req_ext_acq | input | 1 | 1 = two-write hold-open acquisition |
| req_acq_cycles | input | ACQ_W | Hold-open length in cycles (0 treated as 1) |
| abort | input | 1 | Abandon the outstanding conversion |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | 16 | Widened result |
| rsp_chan | output | 3 | Channel tag of the result |
| err_timeout | output | 1 | Interrupt timeout pulse |
| adc_cs_n | output | 1 | Chip-select, active low |
| adc_wr_n | output | 1 | Write strobe, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_int_n | input | 1 | Conversion-done interrupt, active low |
| bus_wdata | output | 8 | Control byte toward the ADC |
| bus_oe | output | 1 | Drive enable for the data lines |
| bus_rdata | input | 12 | Result lines from the ADC |

## Verification
The assertions assume that the ADC raises its interrupt again on the read strobe and on any write, and that the interrupt stays high after reset until a conversion has been started. They also assume `req_acq_cycles` and the request fields are held while `req_valid` waits for `req_ready`. The bench's ADC model clears its interrupt on every write rising edge and on every read falling edge, and reports its result only after a fixed conversion delay that follows a write with bit 5 at 0. Request fields are changed only on falling clock edges and are held until acceptance.

// File: rtl/adcb_pkg.sv
package adcb_pkg;

    localparam int CHAN_W = 3;
    localparam int RES_W  = 12;
    localparam int OUT_W  = 16;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              range_hi;
        logic              bipolar;
        logic [1:0]        clk_mode;
        logic              ext_acq;
    } adcb_req_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WSET,
        S_WSTB,
        S_WHLD,
        S_ACQ,
        S_WAIT,
        S_RSET,
        S_RSTB,
        S_RHLD,
        S_RESP
    } adcb_state_t;

    // Byte layout decoded by the converter: [7:6] clock mode, [5] hold-open,
    // [4] bipolar, [3] range, [2:0] channel.
    function automatic logic [7:0] ctl_byte(adcb_req_t r, logic hold_open);
        return {r.clk_mode, hold_open, r.bipolar, r.range_hi, r.chan};
    endfunction

    function automatic logic [OUT_W-1:0] widen(logic [RES_W-1:0] v, logic signed_fmt);
        return {{(OUT_W-RES_W){signed_fmt & v[RES_W-1]}}, v};
    endfunction

endpackage

// File: rtl/adcb_sync.sv
module adcb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_n,
    output logic q_n
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d_n};
    end

    assign q_n = sh[STAGES-1];
endmodule

// File: rtl/adcb_timer.sv
module adcb_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         expired
);
    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R2: every phase length relies on a strict one-per-cycle countdown
    p_tmr_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/adcb_result.sv
module adcb_result
    import adcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [RES_W-1:0]  raw,
    input  logic              bipolar,
    input  logic [CHAN_W-1:0] chan_in,
    output logic [OUT_W-1:0]  data,
    output logic [CHAN_W-1:0] chan
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            chan <= '0;
        end else if (capture) begin
            data <= widen(raw, bipolar);
            chan <= chan_in;
        end
    end

    // R7: upper bits follow the sign only for bipolar results
    p_sign_fill_r7: assert property (@(posedge clk) disable iff (rst)
        capture |=> (data[OUT_W-1:RES_W] ==
                     {(OUT_W-RES_W){$past(bipolar) & $past(raw[RES_W-1])}}));
endmodule

// File: rtl/adcb_host_ctrl.sv
module adcb_host_ctrl
    import adcb_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int STROBE_CYC  = 3,
    parameter int HOLD_CYC    = 1,
    parameter int TIMEOUT_CYC = 4096,
    parameter int ACQ_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              req_range,
    input  logic              req_bipolar,
    input  logic [1:0]        req_clk_mode,
    input  logic              req_ext_acq,
    input  logic [ACQ_W-1:0]  req_acq_cycles,
    input  logic              abort,
    output logic              rsp_valid,
    output logic [OUT_W-1:0]  rsp_data,
    output logic [CHAN_W-1:0] rsp_chan,
    output logic              err_timeout,
    output logic              adc_cs_n,
    output logic              adc_wr_n,
    output logic              adc_rd_n,
    input  logic              adc_int_n,
    output logic [7:0]        bus_wdata,
    output logic              bus_oe,
    input  logic [RES_W-1:0]  bus_rdata
);
    localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam int TMR_W = (TO_W > ACQ_W) ? TO_W : ACQ_W;
    localparam logic [TMR_W-1:0] SETUP_LD  = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] STROBE_LD = TMR_W'(STROBE_CYC - 1);
    localparam logic [TMR_W-1:0] HOLD_LD   = TMR_W'(HOLD_CYC - 1);
    localparam logic [TMR_W-1:0] TO_LD     = TMR_W'(TIMEOUT_CYC - 1);
    localparam logic [TMR_W-1:0] INT_OPEN  = TMR_W'(TIMEOUT_CYC - 1 - SYNC_STAGES);

    adcb_state_t      state, nxt;
    adcb_req_t        req_q;
    logic [ACQ_W-1:0] acq_q;
    logic             second_q;
    logic             first_ext;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_exp;
    logic             int_s_n;
    logic             int_seen;
    logic             capture;
    logic [TMR_W-1:0] acq_ld;

    adcb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_n(adc_int_n), .q_n(int_s_n)
    );

    adcb_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .cnt(tmr_cnt), .expired(tmr_exp)
    );

    adcb_result u_result (
        .clk(clk), .rst(rst), .capture(capture), .raw(bus_rdata),
        .bipolar(req_q.bipolar), .chan_in(req_q.chan),
        .data(rsp_data), .chan(rsp_chan)
    );

    assign first_ext = req_q.ext_acq && !second_q;
    assign acq_ld    = (acq_q == '0) ? '0 : TMR_W'(acq_q) - 1'b1;
    assign int_seen  = !int_s_n && (tmr_cnt <= INT_OPEN);
    assign capture   = (state == S_RSTB) && tmr_exp;

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            S_IDLE: if (req_valid) begin
                nxt = S_WSET; tmr_load = 1'b1; tmr_val = SETUP_LD;
            end
            S_WSET: if (tmr_exp) begin
                nxt = S_WSTB; tmr_load = 1'b1; tmr_val = STROBE_LD;
            end
            S_WSTB: if (tmr_exp) begin
                nxt = S_WHLD; tmr_load = 1'b1; tmr_val = HOLD_LD;
            end
            S_WHLD: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (first_ext) begin
                    nxt = S_ACQ; tmr_val = acq_ld;
                end else begin
                    nxt = S_WAIT; tmr_val = TO_LD;
                end
            end
            S_ACQ: if (abort) begin
                nxt = S_IDLE;
            end else if (tmr_exp) begin
                nxt = S_WSET; tmr_load = 1'b1; tmr_val = SETUP_LD;
            end
            S_WAIT: if (abort || (tmr_exp && !int_seen)) begin
                nxt = S_IDLE;
            end else if (int_seen) begin
                nxt = S_RSET; tmr_load = 1'b1; tmr_val = SETUP_LD;
            end
            S_RSET: if (tmr_exp) begin
                nxt = S_RSTB; tmr_load = 1'b1; tmr_val = STROBE_LD;
            end
            S_RSTB: if (tmr_exp) begin
                nxt = S_RHLD; tmr_load = 1'b1; tmr_val = HOLD_LD;
            end
            S_RHLD: if (tmr_exp) nxt = S_RESP;
            S_RESP: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            req_q       <= '0;
            acq_q       <= '0;
            second_q    <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            state       <= nxt;
            err_timeout <= (state == S_WAIT) && !abort && tmr_exp && !int_seen;
            if (state == S_IDLE && req_valid) begin
                req_q    <= '{chan: req_chan, range_hi: req_range, bipolar: req_bipolar,
                              clk_mode: req_clk_mode, ext_acq: req_ext_acq};
                acq_q    <= req_acq_cycles;
                second_q <= 1'b0;
            end else if (state == S_ACQ && tmr_exp) begin
                second_q <= 1'b1;
            end
        end
    end

    assign req_ready = (state == S_IDLE);
    assign rsp_valid = (state == S_RESP);
    assign adc_wr_n  = (state != S_WSTB);
    assign adc_rd_n  = (state != S_RSTB);
    assign bus_oe    = (state == S_WSET) || (state == S_WSTB) || (state == S_WHLD);
    assign adc_cs_n  = !(bus_oe || (state == S_RSET) || (state == S_RSTB) || (state == S_RHLD));
    assign bus_wdata = ctl_byte(req_q, first_ext);

    // R6: strobes are only ever issued inside a chip-select window
    p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (rst)
        (!adc_wr_n || !adc_rd_n) |-> !adc_cs_n);
    // R6: nothing drives the data lines during a read
    p_no_drive_read_r6: assert property (@(posedge clk) disable iff (rst)
        !adc_rd_n |-> !bus_oe);
    // R1: byte is held through the end of the write strobe
    p_wdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_wr_n) |-> ($stable(bus_wdata) && bus_oe));
    // R11: ready drops after acceptance
    p_ready_drop_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R7: one-cycle response pulse
    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    // R8: timeout lands in idle
    p_timeout_idle_r8: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> (req_ready && !rsp_valid));
    // R10: quiet bus after reset
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (adc_cs_n && adc_wr_n && adc_rd_n && !bus_oe && req_ready));
endmodule

// File: tb/adcb_host_ctrl_bench.sv
module adcb_host_ctrl_bench;
    localparam int SETUP = 2, STROBE = 3, HOLD = 1, TMO = 300, AW = 8;
    localparam int TXN_LEN = SETUP + STROBE + HOLD;

    typedef struct packed {
        logic [2:0]  ch;
        logic        rng;
        logic        bip;
        logic [1:0]  ck;
        logic        ext;
        logic [7:0]  acq;
        logic [11:0] raw;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd3, 1'b0, 1'b0, 2'b01, 1'b0, 8'd0, 12'hABC, 16'h0ABC},
        '{3'd5, 1'b1, 1'b1, 2'b00, 1'b0, 8'd0, 12'h800, 16'hF800},
        '{3'd0, 1'b0, 1'b1, 2'b10, 1'b1, 8'd5, 12'h7FF, 16'h07FF},
        '{3'd7, 1'b1, 1'b0, 2'b11, 1'b1, 8'd1, 12'hFFF, 16'h0FFF},
        '{3'd2, 1'b0, 1'b1, 2'b01, 1'b1, 8'd0, 12'hFFF, 16'hFFFF},
        '{3'd6, 1'b1, 1'b1, 2'b00, 1'b0, 8'd0, 12'h001, 16'h0001}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_chan = '0;
    logic req_range = 1'b0, req_bipolar = 1'b0, req_ext_acq = 1'b0;
    logic [1:0] req_clk_mode = '0;
    logic [AW-1:0] req_acq_cycles = '0;
    logic abort = 1'b0;
    logic rsp_valid, err_timeout;
    logic [15:0] rsp_data;
    logic [2:0] rsp_chan;
    logic adc_cs_n, adc_wr_n, adc_rd_n, bus_oe;
    logic adc_int_n = 1'b1;
    logic [7:0] bus_wdata;
    logic [11:0] bus_rdata = '0;

    always #4 clk = ~clk;

    adcb_host_ctrl #(.SETUP_CYC(SETUP), .STROBE_CYC(STROBE), .HOLD_CYC(HOLD),
                     .TIMEOUT_CYC(TMO), .ACQ_W(AW), .SYNC_STAGES(2)) u_adcb_host_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_range(req_range), .req_bipolar(req_bipolar),
        .req_clk_mode(req_clk_mode), .req_ext_acq(req_ext_acq),
        .req_acq_cycles(req_acq_cycles), .abort(abort), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_chan(rsp_chan), .err_timeout(err_timeout),
        .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n),
        .adc_int_n(adc_int_n), .bus_wdata(bus_wdata), .bus_oe(bus_oe),
        .bus_rdata(bus_rdata)
    );

    int checks = 0, errors = 0, cyc = 0;

    // ADC model and bus monitor, evaluated on falling edges
    int conv_lat = 12, conv_cnt = 0;
    bit conv_busy = 0, mute = 0;
    logic [11:0] model_val = '0;
    logic prev_wr = 1'b1, prev_rd = 1'b1, prev_cs = 1'b1;
    logic [7:0] wbyte [4];
    int wgap [4];
    int wcnt = 0, rcnt = 0, rd_early = 0, extra_wr = 0, oe_bad = 0, ready_busy = 0;
    int cs_run = 0, hi_run = 0, last_gap = 0, wr_run = 0;
    int wr_len = 0, wcs_len = 0, rcs_len = 0, rsp_cnt = 0, err_cnt = 0;
    bit in_w = 0;
    logic [15:0] got_data = '0;
    logic [2:0] got_chan = '0;

    always @(negedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++; checks++;
            $display("FAIL watchdog act=%0d exp=<100000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (bus_oe && (adc_cs_n || !adc_rd_n)) oe_bad++;
        if (req_ready && !adc_cs_n) ready_busy++;
        if (rsp_valid) begin rsp_cnt++; got_data = rsp_data; got_chan = rsp_chan; end
        if (err_timeout) err_cnt++;
        // chip-select runs
        if (!adc_cs_n) begin
            if (prev_cs) begin last_gap = hi_run; hi_run = 0; end
            cs_run++;
            if (!adc_wr_n) in_w = 1;
        end else begin
            if (!prev_cs) begin
                if (in_w) wcs_len = cs_run; else rcs_len = cs_run;
                cs_run = 0; in_w = 0;
            end
            hi_run++;
        end
        if (!adc_wr_n) wr_run++;
        else if (wr_run > 0) begin wr_len = wr_run; wr_run = 0; end
        // converter behaviour
        if (!prev_wr && adc_wr_n) begin
            if (wcnt < 4) begin wbyte[wcnt] = bus_wdata; wgap[wcnt] = last_gap; end
            wcnt++;
            if (conv_busy || !adc_int_n) extra_wr++;
            adc_int_n = 1'b1;
            conv_busy = !bus_wdata[5];
            conv_cnt = conv_lat;
        end else if (conv_busy && !mute) begin
            conv_cnt--;
            if (conv_cnt == 0) begin conv_busy = 0; adc_int_n = 1'b0; bus_rdata = model_val; end
        end
        if (prev_rd && !adc_rd_n) begin
            if (adc_int_n) rd_early++;
            adc_int_n = 1'b1;
            rcnt++;
        end
        prev_wr = adc_wr_n; prev_rd = adc_rd_n; prev_cs = adc_cs_n;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        wcnt = 0; rcnt = 0; rd_early = 0; extra_wr = 0; oe_bad = 0; ready_busy = 0;
        rsp_cnt = 0; err_cnt = 0;
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        req_chan = v.ch; req_range = v.rng; req_bipolar = v.bip;
        req_clk_mode = v.ck; req_ext_acq = v.ext; req_acq_cycles = v.acq;
        model_val = v.raw;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 ready low after accept", {31'd0, req_ready}, 32'd0);
    endtask

    task automatic run_vec(input vec_t v);
        logic [7:0] b0;
        int n;
        int gap_exp;
        clear_logs();
        issue(v);
        n = 0;
        while (rsp_cnt == 0 && n < 3000) begin @(negedge clk); n++; end
        b0 = {v.ck, v.ext, v.bip, v.rng, v.ch};
        gap_exp = (v.acq == 0) ? 1 : int'(v.acq);
        chk("R7 response count", rsp_cnt, 1);
        chk("R7 data", {16'd0, got_data}, {16'd0, v.exp});
        chk("R7 channel tag", {29'd0, got_chan}, {29'd0, v.ch});
        chk("R2 write strobe width", wr_len, STROBE);
        chk("R2 write cs window", wcs_len, TXN_LEN);
        chk("R2 read cs window", rcs_len, TXN_LEN);
        chk("R6 read after interrupt", rd_early, 0);
        chk("R6 R1 bus drive window", oe_bad, 0);
        chk("R5 no write while converting", extra_wr, 0);
        chk("R11 ready only when idle", ready_busy, 0);
        if (!v.ext) begin
            chk("R3 one write", wcnt, 1);
            chk("R3 R1 control byte", {24'd0, wbyte[0]}, {24'd0, b0});
        end else begin
            chk("R4 two writes", wcnt, 2);
            chk("R4 R1 first byte", {24'd0, wbyte[0]}, {24'd0, b0});
            chk("R4 second byte", {24'd0, wbyte[1]}, {24'd0, b0 & 8'hDF});
            chk("R4 hold-open gap", wgap[1], gap_exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 cs_n", {31'd0, adc_cs_n}, 1);
        chk("R10 wr_n/rd_n", {30'd0, adc_wr_n, adc_rd_n}, 3);
        chk("R10 bus_oe", {31'd0, bus_oe}, 0);
        chk("R10 ready", {31'd0, req_ready}, 1);
        chk("R10 rsp/err", {30'd0, rsp_valid, err_timeout}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9 abort while waiting for the interrupt
        clear_logs();
        mute = 1;
        issue(VECS[0]);
        while (wcnt == 0) @(negedge clk);
        repeat (10) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R9 idle after abort in wait", {31'd0, req_ready}, 1);
        repeat (40) @(negedge clk);
        chk("R9 no response after abort", rsp_cnt, 0);

        // R9 abort during the hold-open interval
        clear_logs();
        issue('{3'd1, 1'b0, 1'b0, 2'b00, 1'b1, 8'd200, 12'h123, 16'h0123});
        while (wcnt == 0) @(negedge clk);
        repeat (5) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R9 idle after abort in hold-open", {31'd0, req_ready}, 1);
        repeat (20) @(negedge clk);
        chk("R9 no second write after abort", wcnt, 1);

        // R8 interrupt never arrives
        clear_logs();
        issue(VECS[1]);
        repeat (TMO + 60) @(negedge clk);
        chk("R8 timeout pulse count", err_cnt, 1);
        chk("R8 no response on timeout", rsp_cnt, 0);
        chk("R8 idle after timeout", {31'd0, req_ready}, 1);
        mute = 0;
        conv_busy = 0;

        // R8 recovery: a normal conversion still completes
        run_vec(VECS[2]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule